// File: doc/BRIEF.md
# Multicycle 64-bit Register Machine Core

This block is a small integer processor core. It runs programs held in one word-addressed memory of 64-bit words. It has eight 64-bit general registers, a program counter, a downward-growing stack pointer and three mutually exclusive compare flags: zero, negative and positive. Each instruction is a group of one to three consecutive words. The low byte of the first word is the operation code. The words that follow give a destination and a source operand, which can be a register index, an absolute address, an immediate value or a jump target.

The core drives a single-port synchronous RAM. The RAM takes an access strobe, a write enable, an address and write data, and it returns read data one cycle after the strobe. The core spends one state on each memory access, so it never makes more than one access per cycle. The host loads a program, holds reset, releases reset and waits for the halted output. A debug read port shows any register, and the flag outputs show the compare state.

Top module: `mc_core64`

## Requirements
- R1: While reset is high, every register and flag is cleared. The stack pointer is set to MEM_WORDS-1 and the program counter to all ones. In the first cycle after reset is released, the core issues a read of address 0 and halted is low.
- R2: Before each fetch the program counter is incremented by one. Only the low 8 bits of the fetched word select the operation, and the upper bits are ignored. The codes are as follows. Compare and flag: 0 clear flags, 1 compare register with register, 2 compare register with immediate. Data movement: 5 copy, 7 store, 9 load, 11 load immediate, 13 push, 14 pop. Arithmetic: 17 increment, 18 decrement, 19 add, 20 subtract, 21 multiply. Branches: 27 on negative, 28 on positive, 29 on zero, 30 on not zero, 31 unconditional. Shift and bitwise: 32 shift left, 33 arithmetic shift right, 34 and, 35 or, 36 bitwise not, 37 xor. Logical: 38 logical and, 39 logical or, 40 logical not. Stop: 41 halt.
- R3: Codes 1, 2, 5, 7, 9, 11, 19 to 21 and 32 to 35 and 37 to 39 take two operand words, and the PC advances by 2 after them. Codes 13, 14, 17, 18, 36, 40 and an untaken branch take one operand word, and the PC advances by 1. Code 0 takes no operand word. Codes 3, 4, 6, 8, 10, 12, 15, 16 and 22 to 26 change no register, memory word or flag, but advance the PC as two-operand codes do, except codes 15 and 16, which advance as one-operand codes do. A register index is the low 3 bits of its operand word.
- R4: A compare computes destination register minus either the source register (code 1) or the raw source word (code 2). It then sets exactly one flag: zero if the difference is 0, negative if bit 63 of the difference is set, positive otherwise. No other code changes the flags, apart from code 0.
- R5: Code 0 clears all three flags and is a single word.
- R6: A branch reads its target from the word after the operation code. When taken, it loads that target into the PC, so the next operation code is read from target+1. When not taken, the next operation code is read from the word after the target word.
- R7: Push first decrements SP, then writes the named register to memory at SP. The first push after reset therefore lands at MEM_WORDS-2. Pop reads memory at SP into the named register, then increments SP.
- R8: Store writes the source register to the absolute address held in the destination word. Load reads the word at the absolute address in the source word. Load immediate writes the source word itself. Copy writes the source register.
- R9: Add, subtract and multiply write the low 64 bits of the result to the destination register. Increment and decrement change the destination register by one.
- R10: And, or, xor and bitwise not act bitwise. The shift amount is the low 6 bits of the source register. Shift right copies the sign bit into the vacated bits.
- R11: Logical and and logical or write 1 or 0 from whether each operand is non-zero. Logical not writes 1 only when the register is zero, and writes 0 otherwise.
- R12: Once the halt code is decoded, halted is high and stays high until reset, and the memory strobe and write enable stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the program |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable, only with mem_en |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read strobe |
| halted | output | 1 | Core has stopped |
| dbg_sel | input | RIW | Register index for the debug port |
| dbg_data | output | 64 | Content of the selected register |
| flag_zero | output | 1 | Last compare gave zero |
| flag_neg | output | 1 | Last compare gave a negative result |
| flag_pos | output | 1 | Last compare gave a positive result |

## Verification
On every cycle, the embedded assertions check four things. The flags stay mutually exclusive. The flags move only in the execute step of a compare or a clear. The halted state holds and stays off the memory bus. Each push and each unconditional jump leaves the stack pointer and program counter where they should be. Only the bench's programs can show the results of whole instruction sequences: a factorial loop that uses a not-zero branch, the stack and store/load round trip with exact addresses and data, the bitwise and logical results, and the ignored upper opcode and index bits. Those programs also show taken and untaken branches for each condition, and that the floating-point and divide codes are skipped without touching state.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int XLEN = 64;
    localparam int OPW  = 8;

    localparam logic [OPW-1:0] OP_CLRF   = 8'd0;
    localparam logic [OPW-1:0] OP_CMPRR  = 8'd1;
    localparam logic [OPW-1:0] OP_CMPRI  = 8'd2;
    localparam logic [OPW-1:0] OP_FCMP   = 8'd3;
    localparam logic [OPW-1:0] OP_FCMPI  = 8'd4;
    localparam logic [OPW-1:0] OP_COPY   = 8'd5;
    localparam logic [OPW-1:0] OP_FCOPY  = 8'd6;
    localparam logic [OPW-1:0] OP_STORE  = 8'd7;
    localparam logic [OPW-1:0] OP_FSTORE = 8'd8;
    localparam logic [OPW-1:0] OP_LOAD   = 8'd9;
    localparam logic [OPW-1:0] OP_FLOAD  = 8'd10;
    localparam logic [OPW-1:0] OP_LDIMM  = 8'd11;
    localparam logic [OPW-1:0] OP_FLDIMM = 8'd12;
    localparam logic [OPW-1:0] OP_PUSH   = 8'd13;
    localparam logic [OPW-1:0] OP_POP    = 8'd14;
    localparam logic [OPW-1:0] OP_FPUSH  = 8'd15;
    localparam logic [OPW-1:0] OP_FPOP   = 8'd16;
    localparam logic [OPW-1:0] OP_INCR   = 8'd17;
    localparam logic [OPW-1:0] OP_DECR   = 8'd18;
    localparam logic [OPW-1:0] OP_ADD    = 8'd19;
    localparam logic [OPW-1:0] OP_SUB    = 8'd20;
    localparam logic [OPW-1:0] OP_MUL    = 8'd21;
    localparam logic [OPW-1:0] OP_DIV    = 8'd22;
    localparam logic [OPW-1:0] OP_BRNEG  = 8'd27;
    localparam logic [OPW-1:0] OP_BRPOS  = 8'd28;
    localparam logic [OPW-1:0] OP_BRZERO = 8'd29;
    localparam logic [OPW-1:0] OP_BRNZ   = 8'd30;
    localparam logic [OPW-1:0] OP_JUMP   = 8'd31;
    localparam logic [OPW-1:0] OP_SLL    = 8'd32;
    localparam logic [OPW-1:0] OP_SRA    = 8'd33;
    localparam logic [OPW-1:0] OP_AND    = 8'd34;
    localparam logic [OPW-1:0] OP_OR     = 8'd35;
    localparam logic [OPW-1:0] OP_NOT    = 8'd36;
    localparam logic [OPW-1:0] OP_XOR    = 8'd37;
    localparam logic [OPW-1:0] OP_LAND   = 8'd38;
    localparam logic [OPW-1:0] OP_LOR    = 8'd39;
    localparam logic [OPW-1:0] OP_LNOT   = 8'd40;
    localparam logic [OPW-1:0] OP_HALT   = 8'd41;

    typedef struct packed {
        logic zero;
        logic neg;
        logic pos;
    } flags_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPC,
        ST_DST,
        ST_SRC,
        ST_EXEC,
        ST_LDW,
        ST_HALT
    } state_e;

    // Number of operand words following the operation code; also the PC step.
    function automatic logic [1:0] op_len(input logic [OPW-1:0] op);
        logic [1:0] n;
        if (op == OP_CLRF || op == OP_HALT) begin
            n = 2'd0;
        end else if (op inside {OP_PUSH, OP_POP, OP_FPUSH, OP_FPOP, OP_INCR,
                                OP_DECR, OP_NOT, OP_LNOT, OP_BRNEG, OP_BRPOS,
                                OP_BRZERO, OP_BRNZ, OP_JUMP}) begin
            n = 2'd1;
        end else if (op < OP_HALT) begin
            n = 2'd2;
        end else begin
            n = 2'd0;
        end
        return n;
    endfunction

    function automatic logic is_branch(input logic [OPW-1:0] op);
        return op inside {OP_BRNEG, OP_BRPOS, OP_BRZERO, OP_BRNZ, OP_JUMP};
    endfunction

    function automatic logic branch_taken(input logic [OPW-1:0] op, input flags_t f);
        logic t;
        case (op)
            OP_BRNEG:  t = f.neg;
            OP_BRPOS:  t = f.pos;
            OP_BRZERO: t = f.zero;
            OP_BRNZ:   t = !f.zero;
            OP_JUMP:   t = 1'b1;
            default:   t = 1'b0;
        endcase
        return t;
    endfunction

    function automatic logic touches_flags(input logic [OPW-1:0] op);
        return op inside {OP_CLRF, OP_CMPRR, OP_CMPRI};
    endfunction

    // Operations whose register result comes from the ALU in the execute step.
    function automatic logic alu_writes(input logic [OPW-1:0] op);
        return op inside {OP_COPY, OP_LDIMM, OP_INCR, OP_DECR, OP_ADD, OP_SUB,
                          OP_MUL, OP_SLL, OP_SRA, OP_AND, OP_OR, OP_NOT,
                          OP_XOR, OP_LAND, OP_LOR, OP_LNOT};
    endfunction

    function automatic logic needs_mem_read(input logic [OPW-1:0] op);
        return op == OP_LOAD || op == OP_POP;
    endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int NREGS = 8,
    parameter int W     = 64,
    parameter int IW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    input  logic [IW-1:0] rdbg,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb,
    output logic [W-1:0]  qdbg,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && wa == IW'(g)) begin
                regs[g] <= wd;
            end
        end
    end

    assign qa   = regs[ra];
    assign qb   = regs[rb];
    assign qdbg = regs[rdbg];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_core_pkg::*;
(
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] res,
    output flags_t          cmp
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int SHW = $clog2(XLEN);

    logic [XLEN-1:0] rhs;
    logic [XLEN-1:0] diff;
    logic [SHW-1:0]  sh;

    assign rhs  = (op == OP_CMPRI) ? imm : b;
    assign diff = a - rhs;
    assign sh   = b[SHW-1:0];

    always_comb begin
        cmp.zero = (diff == '0);
        cmp.neg  = diff[XLEN-1];
        cmp.pos  = !diff[XLEN-1] && (diff != '0);
    end

    always_comb begin
        case (op)
            OP_COPY:  res = b;
            OP_LDIMM: res = imm;
            OP_INCR:  res = a + XLEN'(1);
            OP_DECR:  res = a - XLEN'(1);
            OP_ADD:   res = a + b;
            OP_SUB:   res = a - b;
            OP_MUL:   res = a * b;
            OP_SLL:   res = a << sh;
            OP_SRA:   res = XLEN'($signed(a) >>> sh);
            OP_AND:   res = a & b;
            OP_OR:    res = a | b;
            OP_NOT:   res = ~a;
            OP_XOR:   res = a ^ b;
            OP_LAND:  res = XLEN'((a != '0) && (b != '0));
            OP_LOR:   res = XLEN'((a != '0) || (b != '0));
            OP_LNOT:  res = XLEN'(a == '0);
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
    import mc_core_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int NREGS     = 8,
    parameter int AW        = $clog2(MEM_WORDS),
    parameter int RIW       = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [RIW-1:0]  rf_ra,
    output logic [RIW-1:0]  rf_rb,
    input  logic [XLEN-1:0] rd_a,
    input  logic [XLEN-1:0] rd_b,
    output logic            rf_we,
    output logic [RIW-1:0]  rf_wa,
    output logic [XLEN-1:0] rf_wd,
    output logic [OPW-1:0]  alu_op,
    output logic [XLEN-1:0] alu_imm,
    input  logic [XLEN-1:0] alu_res,
    input  flags_t          alu_flags,
    output flags_t          flags_o,
    output logic            halted
);
    timeunit 1ns;
    timeprecision 100ps;

    state_e          st_q;
    logic [AW-1:0]   pc_q;
    logic [AW-1:0]   sp_q;
    logic [AW-1:0]   dst_q;
    logic [XLEN-1:0] src_q;
    logic [OPW-1:0]  opc_q;
    flags_t          flg_q;

    logic [1:0]      len_cur;
    logic [1:0]      len_new;
    logic [AW-1:0]   pc_inc;
    logic [OPW-1:0]  rd_op;

    assign rd_op   = mem_rdata[OPW-1:0];
    assign len_cur = op_len(opc_q);
    assign len_new = op_len(rd_op);
    assign pc_inc  = pc_q + AW'(1);

    assign rf_ra   = dst_q[RIW-1:0];
    assign rf_rb   = src_q[RIW-1:0];
    assign alu_op  = opc_q;
    assign alu_imm = src_q;
    assign flags_o = flg_q;
    assign halted  = (st_q == ST_HALT);

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = rd_a;
        rf_we     = 1'b0;
        rf_wa     = dst_q[RIW-1:0];
        rf_wd     = alu_res;
        case (st_q)
            ST_FETCH: begin
                mem_en   = 1'b1;
                mem_addr = pc_inc;
            end
            ST_OPC: begin
                if (rd_op != OP_HALT && len_new != 2'd0) begin
                    mem_en   = 1'b1;
                    mem_addr = pc_inc;
                end
            end
            ST_DST: begin
                if (len_cur == 2'd2) begin
                    mem_en   = 1'b1;
                    mem_addr = pc_q + AW'(2);
                end
            end
            ST_EXEC: begin
                case (opc_q)
                    OP_LOAD: begin
                        mem_en   = 1'b1;
                        mem_addr = src_q[AW-1:0];
                    end
                    OP_POP: begin
                        mem_en   = 1'b1;
                        mem_addr = sp_q;
                    end
                    OP_STORE: begin
                        mem_en    = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = dst_q;
                        mem_wdata = rd_b;
                    end
                    OP_PUSH: begin
                        mem_en    = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = sp_q - AW'(1);
                        mem_wdata = rd_a;
                    end
                    default: rf_we = alu_writes(opc_q);
                endcase
            end
            ST_LDW: begin
                rf_we = 1'b1;
                rf_wd = mem_rdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_FETCH;
            pc_q  <= '1;
            sp_q  <= AW'(MEM_WORDS - 1);
            dst_q <= '0;
            src_q <= '0;
            opc_q <= '0;
            flg_q <= '0;
        end else begin
            case (st_q)
                ST_FETCH: begin
                    pc_q <= pc_inc;
                    st_q <= ST_OPC;
                end
                ST_OPC: begin
                    opc_q <= rd_op;
                    if (rd_op == OP_HALT)       st_q <= ST_HALT;
                    else if (len_new == 2'd0)   st_q <= ST_EXEC;
                    else                        st_q <= ST_DST;
                end
                ST_DST: begin
                    dst_q <= mem_rdata[AW-1:0];
                    st_q  <= (len_cur == 2'd2) ? ST_SRC : ST_EXEC;
                end
                ST_SRC: begin
                    src_q <= mem_rdata;
                    st_q  <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (touches_flags(opc_q)) begin
                        flg_q <= (opc_q == OP_CLRF) ? flags_t'(3'b000) : alu_flags;
                    end
                    if (opc_q == OP_PUSH) begin
                        sp_q <= sp_q - AW'(1);
                    end
                    if (is_branch(opc_q) && branch_taken(opc_q, flg_q)) begin
                        pc_q <= dst_q;
                    end else begin
                        pc_q <= pc_q + AW'(len_cur);
                    end
                    st_q <= needs_mem_read(opc_q) ? ST_LDW : ST_FETCH;
                end
                ST_LDW: begin
                    if (opc_q == OP_POP) begin
                        sp_q <= sp_q + AW'(1);
                    end
                    st_q <= ST_FETCH;
                end
                ST_HALT: st_q <= ST_HALT;
                default: st_q <= ST_HALT;
            endcase
        end
    end

    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flg_q.zero, flg_q.neg, flg_q.pos}));

    // R4
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_EXEC || !touches_flags(opc_q)) |=> $stable(flg_q));

    // R12
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R12
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_en && !mem_we));

    // R12
    write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en);

    // R7
    push_predec_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EXEC && opc_q == OP_PUSH) |=> (sp_q == AW'($past(sp_q) - AW'(1))));

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_EXEC && opc_q == OP_JUMP) |=> (pc_q == $past(dst_q)));
endmodule

// File: rtl/mc_core64.sv
module mc_core64
    import mc_core_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int NREGS     = 8,
    localparam int AW       = $clog2(MEM_WORDS),
    localparam int RIW      = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [63:0]     mem_wdata,
    input  logic [63:0]     mem_rdata,
    output logic            halted,
    input  logic [RIW-1:0]  dbg_sel,
    output logic [63:0]     dbg_data,
    output logic            flag_zero,
    output logic            flag_neg,
    output logic            flag_pos
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [RIW-1:0]  rf_ra;
    logic [RIW-1:0]  rf_rb;
    logic [RIW-1:0]  rf_wa;
    logic [XLEN-1:0] rd_a;
    logic [XLEN-1:0] rd_b;
    logic [XLEN-1:0] rf_wd;
    logic            rf_we;
    logic [OPW-1:0]  alu_op;
    logic [XLEN-1:0] alu_imm;
    logic [XLEN-1:0] alu_res;
    flags_t          alu_flags;
    flags_t          flags;

    mc_seq #(
        .MEM_WORDS (MEM_WORDS),
        .NREGS     (NREGS),
        .AW        (AW),
        .RIW       (RIW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .rf_ra     (rf_ra),
        .rf_rb     (rf_rb),
        .rd_a      (rd_a),
        .rd_b      (rd_b),
        .rf_we     (rf_we),
        .rf_wa     (rf_wa),
        .rf_wd     (rf_wd),
        .alu_op    (alu_op),
        .alu_imm   (alu_imm),
        .alu_res   (alu_res),
        .alu_flags (alu_flags),
        .flags_o   (flags),
        .halted    (halted)
    );

    mc_regfile #(
        .NREGS (NREGS),
        .W     (XLEN),
        .IW    (RIW)
    ) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra   (rf_ra),
        .rb   (rf_rb),
        .rdbg (dbg_sel),
        .qa   (rd_a),
        .qb   (rd_b),
        .qdbg (dbg_data),
        .we   (rf_we),
        .wa   (rf_wa),
        .wd   (rf_wd)
    );

    mc_alu u_alu (
        .op  (alu_op),
        .a   (rd_a),
        .b   (rd_b),
        .imm (alu_imm),
        .res (alu_res),
        .cmp (alu_flags)
    );

    assign flag_zero = flags.zero;
    assign flag_neg  = flags.neg;
    assign flag_pos  = flags.pos;
endmodule

// File: tb/sim_mc_core64.sv
module sim_mc_core64;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MW  = 256;
    localparam int AWB = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            mem_en, mem_we;
    logic [AWB-1:0]  mem_addr;
    logic [63:0]     mem_wdata;
    logic [63:0]     mem_rdata = '0;
    logic            halted;
    logic [2:0]      dbg_sel = '0;
    logic [63:0]     dbg_data;
    logic            flag_zero, flag_neg, flag_pos;

    logic            ld_en = 1'b0;
    logic [AWB-1:0]  ld_addr = '0;
    logic [63:0]     ld_data = '0;
    logic [63:0]     ram [MW];

    int n_chk  = 0;
    int n_fail = 0;
    int ptr    = 0;

    int          exp_a[$];
    logic [63:0] exp_v[$];
    string       exp_r[$];

    always #2.5 clk = ~clk;

    mc_core64 #(.MEM_WORDS(MW), .NREGS(8)) u0 (
        .clk(clk), .rst(rst),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_pos(flag_pos)
    );

    // Synchronous RAM model with a bench load port.
    always @(posedge clk) begin
        if (ld_en) begin
            ram[ld_addr] <= ld_data;
        end else if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: each write seen on the bus is matched to the queue head.
    always @(negedge clk) begin
        if (!rst && mem_en && mem_we) begin
            if (exp_a.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R3/R8 unexpected write: got addr %0d data %h expected none",
                         mem_addr, mem_wdata);
            end else begin
                automatic int          ea = exp_a.pop_front();
                automatic logic [63:0] ev = exp_v.pop_front();
                automatic string       er = exp_r.pop_front();
                chk({er, " write address"}, 64'(mem_addr), 64'(ea));
                chk({er, " write data"}, mem_wdata, ev);
            end
        end
    end

    task automatic expect_write(input int a, input logic [63:0] v, input string req);
        exp_a.push_back(a);
        exp_v.push_back(v);
        exp_r.push_back(req);
    endtask

    task automatic put(input logic [63:0] v);
        ld_en   = 1'b1;
        ld_addr = AWB'(ptr);
        ld_data = v;
        @(negedge clk);
        ptr++;
    endtask

    task automatic load_begin();
        rst = 1'b1;
        @(negedge clk);
        ptr = 0;
        for (int i = 0; i < MW; i++) put(64'd0);
        ptr = 0;
    endtask

    task automatic check_reg(input int idx, input logic [63:0] v, input string req);
        dbg_sel = 3'(idx);
        #0.1;
        chk(req, dbg_data, v);
    endtask

    task automatic check_flags(input logic [2:0] zng, input string req);
        chk(req, 64'({flag_zero, flag_neg, flag_pos}), 64'(zng));
    endtask

    // Release reset after checking the reset state, then run to halt.
    task automatic run_program();
        int k;
        int busy;
        ld_en = 1'b0;
        @(negedge clk);
        chk("R1 halted during reset", 64'(halted), 64'd0);
        check_flags(3'b000, "R1 flags after reset");
        for (int i = 0; i < 8; i++) check_reg(i, 64'd0, "R1 register cleared");
        rst = 1'b0;
        #0.2;
        chk("R1 first access strobe", 64'(mem_en), 64'd1);
        chk("R1 first fetch address", 64'(mem_addr), 64'd0);
        chk("R1 first access is a read", 64'(mem_we), 64'd0);
        k = 0;
        while (!halted && k < 4000) begin
            @(negedge clk);
            k++;
        end
        chk("R12 halted reached", 64'(halted), 64'd1);
        busy = 0;
        repeat (12) begin
            @(negedge clk);
            if (mem_en || mem_we || !halted) busy++;
        end
        chk("R12 quiet after halt", 64'(busy), 64'd0);
        chk("R7/R8 all expected writes seen", 64'(exp_a.size()), 64'd0);
    endtask

    // Program A: factorial loop, stack, store/load, skipped codes, wide opcode word.
    task automatic prog_a();
        load_begin();
        put(11); put(0); put(1);
        put(11); put(1); put(5);
        put(5);  put(2); put(0);
        put(21); put(0); put(1);
        put(20); put(1); put(2);
        put(2);  put(1); put(0);
        put(30); put(8);
        put(13); put(0);
        put(14); put(7);
        put(11); put(6); put(2);
        put(7);  put(200); put(7);
        put(9);  put(5); put(200);
        put(19); put(7); put(2);
        put(22); put(7); put(6);
        put(23); put(0); put(0);
        put(15); put(0);
        put(64'hABCD_0000_0000_0011); put(64'h0000_0000_0000_FF08);
        put(41);
        expect_write(MW - 2, 64'd120, "R7 push");
        expect_write(200, 64'd120, "R8 store");
        run_program();
        check_reg(0, 64'd121, "R9 multiply loop then R2 wide-opcode increment");
        check_reg(1, 64'd0,   "R6 not-zero loop exit");
        check_reg(2, 64'd1,   "R8 copy");
        check_reg(5, 64'd120, "R8 load");
        check_reg(6, 64'd2,   "R8 load immediate");
        check_reg(7, 64'd121, "R3 divide skipped after R7 pop and R9 add");
        check_flags(3'b100, "R4 compare-zero flag kept past later ops");
    endtask

    // Program B: bitwise, shifts, logical ops, negative compare.
    task automatic prog_b();
        load_begin();
        put(11); put(0); put(5);
        put(11); put(1); put(3);
        put(11); put(2); put(6);
        put(35); put(0); put(1);
        put(37); put(1); put(2);
        put(11); put(4); put(7);
        put(36); put(4);
        put(11); put(5); put(12);
        put(34); put(5); put(1);
        put(11); put(6); put(64'hFFFF_FFFF_FFFF_FFF0);
        put(11); put(3); put(2);
        put(33); put(6); put(3);
        put(11); put(7); put(1);
        put(32); put(7); put(3);
        put(38); put(2); put(3);
        put(11); put(3); put(0);
        put(39); put(3); put(0);
        put(40); put(3);
        put(1);  put(6); put(7);
        put(41);
        run_program();
        check_reg(0, 64'd7, "R10 or");
        check_reg(1, 64'd5, "R10 xor");
        check_reg(2, 64'd1, "R11 logical and");
        check_reg(3, 64'd0, "R11 logical or then not of non-zero");
        check_reg(4, 64'hFFFF_FFFF_FFFF_FFF8, "R10 bitwise not");
        check_reg(5, 64'd4, "R10 and");
        check_reg(6, 64'hFFFF_FFFF_FFFF_FFFC, "R10 arithmetic shift right");
        check_reg(7, 64'd4, "R10 shift left");
        check_flags(3'b010, "R4 negative compare");
    endtask

    // Program C: branches taken and untaken, clear flags, logical not of zero.
    task automatic prog_c();
        load_begin();
        put(11); put(0); put(0);
        put(11); put(1); put(1);
        put(17); put(1);
        put(18); put(1);
        put(11); put(3); put(1);
        put(1);  put(0); put(1);
        put(27); put(21);
        put(11); put(6); put(99);
        put(0);
        put(1);  put(1); put(3);
        put(27); put(40);
        put(29); put(32);
        put(11); put(6); put(77);
        put(0);
        put(1);  put(1); put(0);
        put(28); put(41);
        put(11); put(6); put(55);
        put(0);
        put(2);  put(1); put(1);
        put(30); put(50);
        put(28); put(50);
        put(40); put(0);
        put(0);
        put(31); put(56);
        put(17); put(0);
        put(0);
        put(41);
        run_program();
        check_reg(6, 64'd0, "R6 taken branches skip their fall-through words");
        check_reg(1, 64'd1, "R9 increment then decrement");
        check_reg(0, 64'd1, "R11 logical not of zero; R6 jump skips increment");
        check_reg(3, 64'd1, "R8 load immediate");
        check_flags(3'b000, "R5 clear flags");
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: got halted=%0d expected run to finish", halted);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        prog_a();
        prog_b();
        prog_c();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule